// File: doc/BRIEF.md
# Accumulator Execute and Branch Unit

This block carries out one already-resolved instruction against a single signed accumulator. The instruction arrives as a local opcode, an operand (an immediate or a word already fetched from memory), an effective address, the current program counter and an index-register selector. On a one-cycle execute strobe the unit updates the accumulator. It may also raise a memory write request, an index-register write or a branch decision. A halt code freezes the unit until reset.

No condition flags exist. The jump codes test the accumulator value held at the moment of the strobe, so that value is the one before the jumping instruction executes. Several codes ignore the operand entirely. Address resolution and floating-point work belong to the neighbouring blocks.

The control path is a two-state machine. `ST_RUN` accepts strobes and `ST_HALTED` ignores them. There are two transitions. `RUN_TO_HALT` is taken on a strobe that carries the halt code. `ANY_TO_RUN` is taken only by reset.

Top module: `acc_exec_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `acc_o` is 0, `pc_next_o` is 0, `halt_o` is 0, and the pulse outputs `mem_we_o`, `idx_we_o`, `branch_taken_o` and `div_err_o` are 0.
- R2: Code 0 (load) puts the operand into the accumulator. Code 1 (store) raises `mem_we_o` for the cycle after the strobe, with `mem_addr_o` equal to the effective address and `mem_wdata_o` equal to the accumulator value before the strobe.
- R3: Code 3 (add) and code 4 (subtract, accumulator minus operand) wrap modulo 2^32 and give no overflow indication.
- R4: Code 5 (multiply) keeps the low 32 bits of the signed product. Code 6 (divide) gives the signed quotient truncated toward zero. A divisor of -1 yields the two's-complement negation of the accumulator.
- R5: Code 6 with a zero operand leaves the accumulator unchanged and raises `div_err_o` for exactly one cycle.
- R6: Code 7 (sign change) replaces the accumulator with its two's-complement negation. Code 10 (NOT) inverts every bit. Both ignore the operand.
- R7: Code 8 (AND) and code 9 (OR) combine the accumulator and the operand bit by bit and store the result in the accumulator.
- R8: Code 11 (shift left) and code 12 (shift right) are logical shifts of the accumulator. The shift amount is the low 5 bits of the operand.
- R9: Code 13 jumps when accumulator bit 31 is set, code 15 jumps when the accumulator is zero, and code 14 always jumps. A taken jump sets `pc_next_o` to the effective address and pulses `branch_taken_o`. Every other executed instruction sets `pc_next_o` to `pc_i + 1`.
- R10: Code 2 (load-index) pulses `idx_we_o` with `idx_sel_o` equal to `idx_sel_i` and `idx_wdata_o` equal to the operand. When the selector is 0, no write pulse is raised.
- R11: Code 16 (halt) sets `halt_o` from the next cycle until reset. After that, strobes change no output.
- R12: Without a strobe, no output changes and no pulse is raised. Codes 17 to 31 leave the accumulator unchanged and only advance `pc_next_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | One-cycle execute strobe |
| opcode_i | input | 5 | Local operation code |
| operand_i | input | DW | Resolved operand |
| eff_addr_i | input | AW | Effective address |
| pc_i | input | AW | Current program counter |
| idx_sel_i | input | IW | Index register selector |
| acc_o | output | DW | Accumulator |
| mem_we_o | output | 1 | Store request pulse |
| mem_addr_o | output | AW | Store address |
| mem_wdata_o | output | DW | Store data |
| idx_we_o | output | 1 | Index write pulse |
| idx_sel_o | output | IW | Index register written |
| idx_wdata_o | output | DW | Index write data |
| pc_next_o | output | AW | Next program counter |
| branch_taken_o | output | 1 | Jump taken pulse |
| halt_o | output | 1 | Halted |
| div_err_o | output | 1 | Divide-by-zero pulse |

## Verification
The bench builds the unit with its defaults: a 32-bit accumulator, a 16-bit address and 16 index registers. This width brings the signed wrap from 0x7FFFFFFF to 0x80000000 within reach, as well as the most-negative value divided by -1 and shifts whose operand has bits above the low five. The 16-entry index space lets the bench drive both selector 0, which is suppressed, and a non-zero selector. A reset issued after a halt checks that the halted state clears only through reset.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;
    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 5'd0,
        OP_STORE = 5'd1,
        OP_LDX   = 5'd2,
        OP_ADD   = 5'd3,
        OP_SUB   = 5'd4,
        OP_MUL   = 5'd5,
        OP_DIV   = 5'd6,
        OP_NEGS  = 5'd7,
        OP_AND   = 5'd8,
        OP_OR    = 5'd9,
        OP_NOT   = 5'd10,
        OP_SHL   = 5'd11,
        OP_SHR   = 5'd12,
        OP_JNEG  = 5'd13,
        OP_JMP   = 5'd14,
        OP_JZERO = 5'd15,
        OP_HALT  = 5'd16
    } op_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_HALTED = 1'b1
    } exec_state_e;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_exec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [DW-1:0]   acc_i,
    input  logic [DW-1:0]   opnd_i,
    output logic [DW-1:0]   result_o,
    output logic            div_zero_o
);
    localparam int SHAMT_W = $clog2(DW);
    localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

    logic [SHAMT_W-1:0] shamt;
    logic [DW-1:0]      quotient;

    assign shamt = opnd_i[SHAMT_W-1:0];

    always_comb begin
        if (opnd_i == ALL_ONES) begin
            quotient = '0 - acc_i;
        end else if (opnd_i == '0) begin
            quotient = acc_i;
        end else begin
            quotient = DW'($signed(acc_i) / $signed(opnd_i));
        end
    end

    always_comb begin
        result_o   = acc_i;
        div_zero_o = 1'b0;
        case (op_i)
            OP_LOAD: result_o = opnd_i;
            OP_ADD:  result_o = acc_i + opnd_i;
            OP_SUB:  result_o = acc_i - opnd_i;
            OP_MUL:  result_o = acc_i * opnd_i;
            OP_DIV: begin
                result_o   = quotient;
                div_zero_o = (opnd_i == '0);
            end
            OP_NEGS: result_o = '0 - acc_i;
            OP_AND:  result_o = acc_i & opnd_i;
            OP_OR:   result_o = acc_i | opnd_i;
            OP_NOT:  result_o = ~acc_i;
            OP_SHL:  result_o = acc_i << shamt;
            OP_SHR:  result_o = acc_i >> shamt;
            default: result_o = acc_i;
        endcase
    end
endmodule

// File: rtl/acc_branch_unit.sv
module acc_branch_unit
    import acc_exec_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 16
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [DW-1:0]   acc_i,
    input  logic [AW-1:0]   eff_addr_i,
    input  logic [AW-1:0]   pc_i,
    output logic            taken_o,
    output logic [AW-1:0]   next_pc_o
);
    localparam logic [AW-1:0] PC_STEP = {{(AW-1){1'b0}}, 1'b1};

    logic acc_neg;
    logic acc_zero;

    assign acc_neg  = acc_i[DW-1];
    assign acc_zero = (acc_i == '0);

    always_comb begin
        case (op_i)
            OP_JNEG:  taken_o = acc_neg;
            OP_JZERO: taken_o = acc_zero;
            OP_JMP:   taken_o = 1'b1;
            default:  taken_o = 1'b0;
        endcase
        next_pc_o = taken_o ? eff_addr_i : (pc_i + PC_STEP);
    end
endmodule

// File: rtl/acc_exec_fsm.sv
module acc_exec_fsm
    import acc_exec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exec_i,
    input  logic is_halt_i,
    output logic fire_o,
    output logic halted_o
);
    exec_state_e state_q;
    exec_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        fire_o   = 1'b0;
        halted_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                fire_o = exec_i;
                if (exec_i && is_halt_i) begin
                    state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                halted_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int N_IDX = 16,
    localparam int IW   = $clog2(N_IDX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_i,
    input  logic [OP_W-1:0] opcode_i,
    input  logic [DW-1:0]   operand_i,
    input  logic [AW-1:0]   eff_addr_i,
    input  logic [AW-1:0]   pc_i,
    input  logic [IW-1:0]   idx_sel_i,
    output logic [DW-1:0]   acc_o,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [DW-1:0]   mem_wdata_o,
    output logic            idx_we_o,
    output logic [IW-1:0]   idx_sel_o,
    output logic [DW-1:0]   idx_wdata_o,
    output logic [AW-1:0]   pc_next_o,
    output logic            branch_taken_o,
    output logic            halt_o,
    output logic            div_err_o
);
    logic            fire;
    logic            halted;
    logic [DW-1:0]   alu_result;
    logic            alu_div_zero;
    logic            br_taken;
    logic [AW-1:0]   br_next_pc;
    logic            is_store;
    logic            is_ldx;
    logic            is_halt;

    assign is_store = (opcode_i == OP_STORE);
    assign is_ldx   = (opcode_i == OP_LDX) && (idx_sel_i != '0);
    assign is_halt  = (opcode_i == OP_HALT);

    acc_exec_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .exec_i    (exec_i),
        .is_halt_i (is_halt),
        .fire_o    (fire),
        .halted_o  (halted)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op_i       (opcode_i),
        .acc_i      (acc_o),
        .opnd_i     (operand_i),
        .result_o   (alu_result),
        .div_zero_o (alu_div_zero)
    );

    acc_branch_unit #(.DW(DW), .AW(AW)) u_branch (
        .op_i       (opcode_i),
        .acc_i      (acc_o),
        .eff_addr_i (eff_addr_i),
        .pc_i       (pc_i),
        .taken_o    (br_taken),
        .next_pc_o  (br_next_pc)
    );

    assign halt_o = halted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o          <= '0;
            pc_next_o      <= '0;
            branch_taken_o <= 1'b0;
            mem_we_o       <= 1'b0;
            mem_addr_o     <= '0;
            mem_wdata_o    <= '0;
            idx_we_o       <= 1'b0;
            idx_sel_o      <= '0;
            idx_wdata_o    <= '0;
            div_err_o      <= 1'b0;
        end else begin
            mem_we_o       <= fire && is_store;
            idx_we_o       <= fire && is_ldx;
            branch_taken_o <= fire && br_taken;
            div_err_o      <= fire && alu_div_zero;
            if (fire) begin
                acc_o     <= alu_result;
                pc_next_o <= br_next_pc;
                if (is_store) begin
                    mem_addr_o  <= eff_addr_i;
                    mem_wdata_o <= acc_o;
                end
                if (is_ldx) begin
                    idx_sel_o   <= idx_sel_i;
                    idx_wdata_o <= operand_i;
                end
            end
        end
    end
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
    parameter int DW = 32,
    parameter int AW = 16,
    parameter int IW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_i,
    input logic [AW-1:0] eff_addr_i,
    input logic [DW-1:0] acc_o,
    input logic          mem_we_o,
    input logic          idx_we_o,
    input logic [IW-1:0] idx_sel_o,
    input logic [AW-1:0] pc_next_o,
    input logic          branch_taken_o,
    input logic          halt_o,
    input logic          div_err_o
);
    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> halt_o);

    // R11
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(halt_o) |-> (!mem_we_o && !idx_we_o && !branch_taken_o && !div_err_o));

    // R2
    store_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(exec_i));

    // R10
    idx_zero_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we_o |-> (idx_sel_o != '0));

    // R12
    acc_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exec_i) |-> ($stable(acc_o) && $stable(pc_next_o)));

    // R5
    div_zero_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_err_o |-> $stable(acc_o));

    // R9
    branch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_taken_o |-> (pc_next_o == $past(eff_addr_i)));

    // R12
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_we_o, idx_we_o, branch_taken_o, div_err_o}) <= 1);
endmodule

bind acc_exec_unit acc_exec_chk #(.DW(DW), .AW(AW), .IW(IW)) u_acc_exec_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exec_i         (exec_i),
    .eff_addr_i     (eff_addr_i),
    .acc_o          (acc_o),
    .mem_we_o       (mem_we_o),
    .idx_we_o       (idx_we_o),
    .idx_sel_o      (idx_sel_o),
    .pc_next_o      (pc_next_o),
    .branch_taken_o (branch_taken_o),
    .halt_o         (halt_o),
    .div_err_o      (div_err_o)
);

// File: tb/test_acc_exec_unit.sv
module test_acc_exec_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [4:0]  opcode_i = '0;
    logic [31:0] operand_i = '0;
    logic [15:0] eff_addr_i = '0;
    logic [15:0] pc_i = '0;
    logic [3:0]  idx_sel_i = '0;
    logic [31:0] acc_o;
    logic        mem_we_o;
    logic [15:0] mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic        idx_we_o;
    logic [3:0]  idx_sel_o;
    logic [31:0] idx_wdata_o;
    logic [15:0] pc_next_o;
    logic        branch_taken_o;
    logic        halt_o;
    logic        div_err_o;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_acc;
    logic [15:0] m_pc;
    logic        m_halt, m_we, m_iwe, m_br, m_derr;
    logic [15:0] m_waddr;
    logic [31:0] m_wdata, m_idata;
    logic [3:0]  m_isel;

    always #10 clk = ~clk;

    acc_exec_unit i_acc_exec_unit (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
        .operand_i(operand_i), .eff_addr_i(eff_addr_i), .pc_i(pc_i),
        .idx_sel_i(idx_sel_i), .acc_o(acc_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .idx_we_o(idx_we_o), .idx_sel_o(idx_sel_o), .idx_wdata_o(idx_wdata_o),
        .pc_next_o(pc_next_o), .branch_taken_o(branch_taken_o),
        .halt_o(halt_o), .div_err_o(div_err_o)
    );

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, "acc", acc_o, m_acc);
        chk(tag, "pc_next", {16'd0, pc_next_o}, {16'd0, m_pc});
        chk(tag, "halt/br/we/iwe/derr",
            {27'd0, halt_o, branch_taken_o, mem_we_o, idx_we_o, div_err_o},
            {27'd0, m_halt, m_br, m_we, m_iwe, m_derr});
        if (m_we) begin
            chk(tag, "mem_addr", {16'd0, mem_addr_o}, {16'd0, m_waddr});
            chk(tag, "mem_wdata", mem_wdata_o, m_wdata);
        end
        if (m_iwe) begin
            chk(tag, "idx_sel", {28'd0, idx_sel_o}, {28'd0, m_isel});
            chk(tag, "idx_wdata", idx_wdata_o, m_idata);
        end
    endtask

    task automatic model_reset();
        m_acc = '0; m_pc = '0; m_halt = 0; m_we = 0; m_iwe = 0; m_br = 0; m_derr = 0;
        m_waddr = '0; m_wdata = '0; m_idata = '0; m_isel = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        exec_i = 1'b0;
        model_reset();
        @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");
    endtask

    // one clock: drive at negedge, model the next state, compare at next negedge
    task automatic step(input logic ex, input logic [4:0] op, input logic [31:0] opnd,
                        input logic [15:0] ea, input logic [15:0] pc, input logic [3:0] sel,
                        input string tag);
        logic taken;
        longint a, b, r;
        exec_i = ex; opcode_i = op; operand_i = opnd; eff_addr_i = ea; pc_i = pc; idx_sel_i = sel;
        m_we = 0; m_iwe = 0; m_br = 0; m_derr = 0;
        if (ex && !m_halt) begin
            a = longint'($signed(m_acc));
            b = longint'($signed(opnd));
            taken = 0;
            case (op)
                5'd0:  m_acc = opnd;
                5'd1:  begin m_we = 1; m_waddr = ea; m_wdata = m_acc; end
                5'd2:  if (sel != 0) begin m_iwe = 1; m_isel = sel; m_idata = opnd; end
                5'd3:  m_acc = 32'(a + b);
                5'd4:  m_acc = 32'(a - b);
                5'd5:  begin r = a * b; m_acc = r[31:0]; end
                5'd6:  if (b == 0) m_derr = 1; else begin r = a / b; m_acc = r[31:0]; end
                5'd7:  m_acc = 32'(-a);
                5'd8:  m_acc = m_acc & opnd;
                5'd9:  m_acc = m_acc | opnd;
                5'd10: m_acc = ~m_acc;
                5'd11: m_acc = m_acc << opnd[4:0];
                5'd12: m_acc = m_acc >> opnd[4:0];
                5'd13: taken = (a < 0);
                5'd14: taken = 1;
                5'd15: taken = (a == 0);
                5'd16: m_halt = 1;
                default: ;
            endcase
            m_br = taken;
            m_pc = taken ? ea : 16'(pc + 16'd1);
        end
        @(posedge clk);
        @(negedge clk);
        exec_i = 1'b0;
        compare(tag);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        step(1, 5'd0, 32'h1234_5678, 16'h0010, 16'h0100, 0, "R2");
        step(1, 5'd1, 32'hDEAD_0000, 16'h0040, 16'h0101, 0, "R2");
        step(1, 5'd0, 32'h7FFF_FFFF, 0, 16'h0102, 0, "R2");
        step(1, 5'd3, 32'h0000_0001, 0, 16'h0103, 0, "R3");
        step(1, 5'd0, 32'h0, 0, 16'h0104, 0, "R2");
        step(1, 5'd4, 32'h0000_0001, 0, 16'h0105, 0, "R3");
        step(1, 5'd0, -32'sd7, 0, 16'h0106, 0, "R2");
        step(1, 5'd5, 32'd6, 0, 16'h0107, 0, "R4");
        step(1, 5'd0, 32'h0001_0000, 0, 16'h0108, 0, "R2");
        step(1, 5'd5, 32'h0001_0003, 0, 16'h0109, 0, "R4");
        step(1, 5'd0, -32'sd7, 0, 16'h010A, 0, "R2");
        step(1, 5'd6, 32'd2, 0, 16'h010B, 0, "R4");
        step(1, 5'd0, 32'd7, 0, 16'h010C, 0, "R2");
        step(1, 5'd6, -32'sd2, 0, 16'h010D, 0, "R4");
        step(1, 5'd0, 32'h8000_0000, 0, 16'h010E, 0, "R2");
        step(1, 5'd6, 32'hFFFF_FFFF, 0, 16'h010F, 0, "R4");
        step(1, 5'd0, 32'd55, 0, 16'h0110, 0, "R2");
        step(1, 5'd6, 32'd0, 0, 16'h0111, 0, "R5");
        step(0, 5'd0, 32'd0, 0, 16'h0112, 0, "R5");
        step(1, 5'd7, 32'd99, 0, 16'h0113, 0, "R6");
        step(1, 5'd10, 32'hFFFF_FFFF, 0, 16'h0114, 0, "R6");
        step(1, 5'd0, 32'hF0F0_3C3C, 0, 16'h0115, 0, "R2");
        step(1, 5'd8, 32'hFF00_0FF0, 0, 16'h0116, 0, "R7");
        step(1, 5'd9, 32'h0000_F00F, 0, 16'h0117, 0, "R7");
        step(1, 5'd0, 32'h8000_0003, 0, 16'h0118, 0, "R2");
        step(1, 5'd11, 32'hFFFF_FFE4, 0, 16'h0119, 0, "R8");
        step(1, 5'd0, 32'h8000_0000, 0, 16'h011A, 0, "R2");
        step(1, 5'd12, 32'd31, 0, 16'h011B, 0, "R8");
        step(1, 5'd11, 32'd33, 0, 16'h011C, 0, "R8");
        step(0, 5'd3, 32'd5, 16'h0333, 16'h0200, 0, "R12");
        step(0, 5'd1, 32'd5, 16'h0333, 16'h0200, 0, "R12");
        step(1, 5'd20, 32'hFFFF_FFFF, 16'h0333, 16'h0201, 0, "R12");
        step(1, 5'd31, 32'h1, 16'h0333, 16'hFFFF, 0, "R12");
        step(1, 5'd0, 32'hFFFF_FFFF, 0, 16'h0300, 0, "R2");
        step(1, 5'd13, 32'd0, 16'h0ABC, 16'h0301, 0, "R9");
        step(1, 5'd15, 32'd0, 16'h0ABD, 16'h0302, 0, "R9");
        step(1, 5'd0, 32'h0, 0, 16'h0303, 0, "R2");
        step(1, 5'd13, 32'd0, 16'h0ABE, 16'h0304, 0, "R9");
        step(1, 5'd15, 32'd0, 16'h0ABF, 16'h0305, 0, "R9");
        step(1, 5'd0, 32'd3, 0, 16'h0306, 0, "R2");
        step(1, 5'd15, 32'd0, 16'h0AC0, 16'h0307, 0, "R9");
        step(1, 5'd14, 32'd0, 16'h0AC1, 16'h0308, 0, "R9");
        step(1, 5'd2, 32'hCAFE_BABE, 0, 16'h0400, 4'd5, "R10");
        step(1, 5'd2, 32'h1111_2222, 0, 16'h0401, 4'd0, "R10");
        step(1, 5'd2, 32'h3333_4444, 0, 16'h0402, 4'd15, "R10");
        step(1, 5'd16, 32'd0, 16'h0500, 16'h0500, 0, "R11");
        step(1, 5'd0, 32'd9, 16'h0501, 16'h0501, 0, "R11");
        step(1, 5'd1, 32'd0, 16'h0502, 16'h0502, 0, "R11");
        step(1, 5'd14, 32'd0, 16'h0503, 16'h0503, 0, "R11");
        step(1, 5'd2, 32'd1, 0, 16'h0504, 4'd3, "R11");
        step(0, 5'd0, 32'd0, 0, 16'h0505, 0, "R11");
        do_reset();
        step(1, 5'd0, 32'd4, 0, 16'h0600, 0, "R1");
        step(1, 5'd3, 32'd4, 0, 16'h0601, 0, "R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule